// File: doc/BRIEF.md
# Stochastic Successive-Approximation ADC Controller

This block is the digital half of a 10-bit analog-to-digital converter. The converter uses no resistor or capacitor DAC. A successive-approximation register proposes a trial code. On every clock the block compares that code with a fresh pseudo-random number. The result is a one-bit stream whose density of ones follows the code. An off-chip RC filter averages the stream into a voltage, and an off-chip comparator tells the block whether the analog input lies below that voltage. The controller reads this decision and resolves one bit per trial, starting at the most significant bit.

The block serves eight input channels and converts them one after another, round-robin, wrapping from 7 back to 0. The `chan` output names the channel being converted, so that an external multiplexer can route that channel's input to the comparator. Software sets the length of each trial through `settle` so that it matches the time constant of the filter. When a conversion ends, the code is stored in that channel's slot of `result` and `done` pulses.

Top module: `stoch_sar_adc`

## Requirements
- R1: While `rst_n` is low, `chan` is 0, `done` is 0, and every slot of `result` is 0.
- R2: `pulse` is 1 in a cycle exactly when the current trial code, taken as unsigned, is greater than the current random number. A 10-bit maximal-length LFSR with period 1023 advances every clock. Over any 1023 consecutive cycles in which the trial code is a nonzero value C, `pulse` is high in exactly C-1 of them.
- R3: Each conversion starts with trial code 512 (only bit 9 set) and resolves bits from bit 9 down to bit 0. When a trial ends with `below` high, the trial bit is cleared; otherwise it is kept. In both cases the next lower bit is set for the next trial. With an ideal averaging filter, the stored result equals the input code.
- R4: Each trial lasts `settle` clocks, and `below` is sampled on the last of them. A conversion therefore takes exactly 10 x `settle` clocks, and conversions follow each other with no idle cycles.
- R5: A `settle` value of 0 behaves like 1.
- R6: `done` is high for exactly one clock after the tenth trial. The result is written into slot k of `result` (bits 10k+9 down to 10k) in that same cycle. No other slot changes.
- R7: Channels are converted in the order 0, 1, ..., 7, then 0 again. `chan` moves to the next channel in the same cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| settle | input | 16 | Clocks per bit trial (0 treated as 1) |
| below | input | 1 | Comparator decision: input is below the filtered stream |
| pulse | output | 1 | Stochastic bitstream feeding the external filter |
| chan | output | 3 | Channel currently being converted |
| done | output | 1 | One-clock pulse at the end of each conversion |
| result | output | 80 | Latched result per channel, 10 bits each, channel 0 in the low bits |

## Verification
The inline assertions check, on every cycle, that `done` never stays high for two clocks, that `chan` steps by exactly one channel and wraps when `done` rises, that the trial code and the result registers change only on the clock that ends a trial, that each conversion starts again at mid-scale, and that the LFSR never locks up at zero. Only the bench's scenarios can show the parts that depend on the analog loop. These are the ones-density of the stream over a full LFSR period, that the resolved codes match known inputs at both ends of the range and in between, the exact spacing of `done` for several `settle` values, and that the other channels' results stay untouched when one slot is written. The bench models the filter as an ideal 1023-cycle moving sum and the comparator as exact.

// File: rtl/stoch_sar_adc.sv
module stoch_sar_adc #(
  parameter int RES  = 10,
  parameter int NCH  = 8,
  parameter int SW   = 16,
  parameter logic [RES-1:0] TAPS = 10'h240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SW-1:0]      settle,
  input  logic               below,
  output logic               pulse,
  output logic [$clog2(NCH)-1:0] chan,
  output logic               done,
  output logic [NCH*RES-1:0] result
);
  localparam int CW = $clog2(NCH);
  localparam int BW = $clog2(RES);
  localparam logic [RES-1:0] MID = RES'(1) << (RES-1);

  logic [RES-1:0] lfsr, trial;
  logic [BW-1:0]  bidx;
  logic [SW-1:0]  cnt;
  logic           dec;
  logic [RES-1:0] mask, kept;

  assign pulse = trial > lfsr;
  assign dec   = ({1'b0, cnt} + 1'b1) >= {1'b0, settle};
  assign mask  = RES'(1) << bidx;
  assign kept  = below ? (trial & ~mask) : trial;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= RES'(1);
    else        lfsr <= {lfsr[RES-2:0], ^(lfsr & TAPS)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trial  <= MID;
      bidx   <= BW'(RES-1);
      cnt    <= '0;
      chan   <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (!dec) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (bidx == '0) begin
          result[chan*RES +: RES] <= kept;
          trial <= MID;
          bidx  <= BW'(RES-1);
          chan  <= (chan == CW'(NCH-1)) ? '0 : chan + 1'b1;
          done  <= 1'b1;
        end else begin
          trial <= kept | (mask >> 1);
          bidx  <= bidx - 1'b1;
        end
      end
    end
  end

  a_r6_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_round_robin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> chan == (($past(chan) == CW'(NCH-1)) ? '0 : $past(chan) + 1'b1));
  a_r3_restart_mid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> trial == MID);
  a_r4_trial_held: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |=> $stable(trial));
  a_r6_result_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec && bidx == '0) |=> $stable(result));
  a_r2_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

// File: tb/sim_stoch_sar_adc.sv
module sim_stoch_sar_adc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] settle = 16'd1024;
  logic        below;
  logic        pulse;
  logic [2:0]  chan;
  logic        done;
  logic [79:0] result;

  int tests = 0, fails = 0, cyc = 0;
  int vin [8] = '{0, 1023, 512, 511, 1, 700, 341, 682};
  logic [1022:0] win;
  int ones;

  always #5 clk = ~clk;

  stoch_sar_adc u0 (.clk(clk), .rst_n(rst_n), .settle(settle), .below(below),
                    .pulse(pulse), .chan(chan), .done(done), .result(result));

  // ideal filter: moving sum of the last 1023 stream bits; exact comparator
  always @(negedge clk) begin
    if (!rst_n) begin win = '0; ones = 0; end
    else begin
      ones = ones + int'(pulse) - int'(win[1022]);
      win  = {win[1021:0], pulse};
    end
  end
  assign below = vin[chan] < ones + 1;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic do_reset(input logic [15:0] s);
    rst_n = 1'b0; settle = s;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(chan == 0, "R1 chan", chan, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(result == '0, "R1 result", int'(result[31:0]), 0);
  endtask

  task automatic t_sweep;
    do_reset(16'd1024);
    while (cyc < 1022) @(negedge clk);
    chk(ones == 511, "R2 ones-density at code 512", ones, 511);
    for (int k = 0; k < 8; k++) begin
      do @(negedge clk); while (!done);
      chk(cyc == 10240 * (k + 1), "R4 conversion length", cyc, 10240 * (k + 1));
      chk(int'(result[k*10 +: 10]) == vin[k], "R3 resolved code", int'(result[k*10 +: 10]), vin[k]);
      chk(int'(chan) == (k + 1) % 8, "R7 channel order", chan, (k + 1) % 8);
      for (int j = k + 1; j < 8; j++)
        chk(result[j*10 +: 10] == '0, "R6 untouched slot", int'(result[j*10 +: 10]), 0);
    end
    for (int k = 0; k < 8; k++)
      chk(int'(result[k*10 +: 10]) == vin[k], "R6 slot kept", int'(result[k*10 +: 10]), vin[k]);
  endtask

  task automatic t_timing(input logic [15:0] s, input int eff, input string req);
    do_reset(s);
    for (int k = 0; k < 9; k++) begin
      do @(negedge clk); while (!done);
      chk(cyc == 10 * eff * (k + 1), req, cyc, 10 * eff * (k + 1));
      chk(int'(chan) == (k + 1) % 8, "R7 wrap order", chan, (k + 1) % 8);
      @(negedge clk);
      chk(done == 0, "R6 single-cycle done", done, 0);
    end
  endtask

  initial begin
    t_reset_state;
    t_sweep;
    t_timing(16'd8, 8, "R4 settle=8 spacing");
    t_timing(16'd0, 1, "R5 settle=0 spacing");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule